// File: doc/BRIEF.md
# Byte ALU with Nibble Flags

This block is the combinational arithmetic and logic stage of an 8-bit accumulator processor. Each cycle it takes the accumulator, a second operand and the current flags byte, together with a 3-bit operation select. From these it produces three things: a result byte, a write strobe for the accumulator and a new flags byte. The surrounding core fetches the operands, decodes the instruction, and registers whatever the block drives.

The operation select is taken straight from bits 5:3 of the instruction. The eight codes cover add, add with carry, subtract, subtract with borrow, and, exclusive-or, or, and compare. Compare is a subtract whose difference is not written back to the accumulator. Carry and half-carry come from a carry chain that is split at the nibble boundary. The subtract-with-borrow rules include the cases where the operands are equal and the borrow-in alone decides the outcome.

Top module: `alu8_nibflag`

## Requirements
- R1: flags_o holds zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4; bits 3:0 are always 0.
- R2: op_i codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 xor, 6 or, 7 compare.
- R3: Add (code 0) returns (a_i + b_i) mod 256. It sets carry on overflow out of bit 7, sets half-carry when the two low nibbles sum above 0xF, and clears subtract.
- R4: Add-with-carry (code 1) behaves like add with flags_i bit 4 added in, and that incoming carry also counts in the nibble half-carry test.
- R5: Subtract (code 2) returns (a_i - b_i) mod 256. It sets subtract, sets carry when a_i < b_i, and sets half-carry when a_i[3:0] < b_i[3:0].
- R6: Subtract-with-borrow (code 3) returns (a_i - b_i - c) mod 256, where c is flags_i bit 4. Carry is set when a_i < b_i, or when the two are equal and c is 1. Half-carry follows the same rule on the low nibbles. Subtract is set.
- R7: When both operands are equal, subtract-with-borrow gives 0x00 with flags 0xC0 if c is 0, and 0xFF with flags 0x70 if c is 1.
- R8: And (code 4) sets half-carry and clears subtract and carry.
- R9: Xor (code 5) and or (code 6) clear subtract, half-carry and carry.
- R10: The zero flag is set exactly when result_o is 0x00, in every operation.
- R11: Compare (code 7) gives the same result_o and flags_o as subtract. acc_we_o is 0 for compare and 1 for every other code.
- R12: Bits 7:5 and 3:0 of flags_i have no effect on result_o, flags_o or acc_we_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flags byte; only bit 4 (carry) is used |
| op_i | input | 3 | Operation select, instruction bits 5:3 |
| result_o | output | 8 | Result byte (the difference for compare) |
| acc_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | New flags byte |

## Verification
The block contains no register, so every output is valid in the same cycle as the inputs that produce it. The bench changes the inputs only on a falling clock edge and reads the outputs just after the next rising edge. That leaves half a period for the paths to settle and keeps any read away from the edge where the inputs change. In the incoming-flags test, both input sets are applied and read back separately, each in its own cycle, and the bench then compares the two observed outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LOW_W  = 4;
  localparam int unsigned FLAG_W = 8;

  localparam int unsigned FLG_Z = 7;
  localparam int unsigned FLG_N = 6;
  localparam int unsigned FLG_H = 5;
  localparam int unsigned FLG_C = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CP  = 3'd7
  } alu_op_e;

  function automatic logic op_takes_carry(alu_op_e op);
    return (op == OP_ADC) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o,
  output logic              carry_o
);
  logic [LOW_W:0]  low_q;
  logic [DATA_W:0] full_q;

  // Out-of-range top bit marks carry on add and borrow on subtract
  always_comb begin
    if (sub_i) begin
      low_q  = {1'b0, a_i[LOW_W-1:0]} - {1'b0, b_i[LOW_W-1:0]} - {{LOW_W{1'b0}}, cin_i};
      full_q = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
    end else begin
      low_q  = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};
      full_q = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    end
  end

  assign res_o   = full_q[DATA_W-1:0];
  assign half_o  = low_q[LOW_W];
  assign carry_o = full_q[DATA_W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end

  assign half_o = (op_i == OP_AND);
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned FLAG_W = 8
) (
  input  logic              z_i,
  input  logic              n_i,
  input  logic              h_i,
  input  logic              c_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_bit
    if (gi == FLG_Z)      begin : g_z assign flags_o[gi] = z_i; end
    else if (gi == FLG_N) begin : g_n assign flags_o[gi] = n_i; end
    else if (gi == FLG_H) begin : g_h assign flags_o[gi] = h_i; end
    else if (gi == FLG_C) begin : g_c assign flags_o[gi] = c_i; end
    else                  begin : g_0 assign flags_o[gi] = 1'b0; end
  end
endmodule

// File: rtl/alu8_nibflag.sv
module alu8_nibflag
  import alu8_pkg::*;
(
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic [7:0] flags_i,
  input  logic [2:0] op_i,
  output logic [7:0] result_o,
  output logic       acc_we_o,
  output logic [7:0] flags_o
);
  alu_op_e           op;
  logic              cin;
  logic              is_sub;
  logic              is_logic;
  logic [DATA_W-1:0] ar_res;
  logic              ar_half;
  logic              ar_carry;
  logic [DATA_W-1:0] lg_res;
  logic              lg_half;
  logic              unused_flags;

  assign op           = alu_op_e'(op_i);
  assign is_sub       = op_is_sub(op);
  assign is_logic     = op_is_logic(op);
  assign cin          = op_takes_carry(op) & flags_i[FLG_C];
  assign unused_flags = ^{flags_i[FLAG_W-1:FLG_C+1], flags_i[FLG_C-1:0]};

  alu8_arith #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin),
    .sub_i  (is_sub),
    .res_o  (ar_res),
    .half_o (ar_half),
    .carry_o(ar_carry)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op),
    .res_o (lg_res),
    .half_o(lg_half)
  );

  assign result_o = is_logic ? lg_res : ar_res;
  assign acc_we_o = (op != OP_CP);

  alu8_flags #(.FLAG_W(FLAG_W)) u_flags (
    .z_i    (result_o == '0),
    .n_i    (is_sub),
    .h_i    (is_logic ? lg_half : ar_half),
    .c_i    (~is_logic & ar_carry),
    .flags_o(flags_o)
  );
endmodule

module alu8_nibflag_chk (
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic [7:0] flags_i,
  input logic [2:0] op_i,
  input logic [7:0] result_o,
  input logic       acc_we_o,
  input logic [7:0] flags_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, flags_i, op_i, result_o, acc_we_o, flags_o});

  always_comb begin
    if (known) begin
      a_r1_low_zero: assert (flags_o[3:0] == 4'h0)
        else $error("low flag bits set");
      a_r10_zero_flag: assert (flags_o[7] == (result_o == 8'h00))
        else $error("zero flag mismatch");
      a_r11_cp_no_write: assert (acc_we_o == (op_i != 3'd7))
        else $error("write strobe wrong");
      a_r5_sub_flags: assert (op_i != 3'd2 ||
                              (flags_o[6] && flags_o[4] == (a_i < b_i) &&
                               flags_o[5] == (a_i[3:0] < b_i[3:0])))
        else $error("subtract flags wrong");
      a_r3_add_nflag: assert (op_i != 3'd0 || !flags_o[6])
        else $error("add sets subtract");
      a_r8_and_flags: assert (op_i != 3'd4 || flags_o[6:4] == 3'b010)
        else $error("and flags wrong");
      a_r9_logic_flags: assert (!(op_i == 3'd5 || op_i == 3'd6) || flags_o[6:4] == 3'b000)
        else $error("xor/or flags wrong");
    end
  end
endmodule

bind alu8_nibflag alu8_nibflag_chk u_chk (.*);

// File: tb/alu8_nibflag_test.sv
module alu8_nibflag_test;
  logic       clk = 1'b0;
  logic [7:0] a_i, b_i, flags_i;
  logic [2:0] op_i;
  logic [7:0] result_o, flags_o;
  logic       acc_we_o;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  alu8_nibflag uut (.*);

  // {op, a, b, flags_in, exp_result, exp_flags, exp_we}
  localparam int NV = 20;
  localparam logic [43:0] VEC [NV] = '{
    {3'd0, 8'h80, 8'h01, 8'h00, 8'h81, 8'h00, 1'b1}, // R3
    {3'd0, 8'h81, 8'h85, 8'h00, 8'h06, 8'h10, 1'b1}, // R3 carry
    {3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h20, 1'b1}, // R3 half
    {3'd0, 8'h80, 8'h80, 8'h00, 8'h00, 8'h90, 1'b1}, // R3 R10
    {3'd1, 8'h0F, 8'h00, 8'h10, 8'h10, 8'h20, 1'b1}, // R4 half via cin
    {3'd1, 8'hFF, 8'h00, 8'h10, 8'h00, 8'hB0, 1'b1}, // R4
    {3'd2, 8'h10, 8'h01, 8'hF0, 8'h0F, 8'h60, 1'b1}, // R5
    {3'd2, 8'h01, 8'h02, 8'h00, 8'hFF, 8'h70, 1'b1}, // R5
    {3'd2, 8'h42, 8'h42, 8'h00, 8'h00, 8'hC0, 1'b1}, // R5
    {3'd3, 8'h42, 8'h42, 8'h10, 8'hFF, 8'h70, 1'b1}, // R6 equal+borrow
    {3'd3, 8'h43, 8'h42, 8'h10, 8'h00, 8'hC0, 1'b1}, // R6
    {3'd3, 8'h50, 8'h4F, 8'h00, 8'h01, 8'h60, 1'b1}, // R6
    {3'd4, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'hA0, 1'b1}, // R8
    {3'd4, 8'hFF, 8'h3C, 8'h00, 8'h3C, 8'h20, 1'b1}, // R8
    {3'd5, 8'h55, 8'h55, 8'h00, 8'h00, 8'h80, 1'b1}, // R9
    {3'd5, 8'hF0, 8'h0F, 8'hF0, 8'hFF, 8'h00, 1'b1}, // R9
    {3'd6, 8'h00, 8'h00, 8'h70, 8'h00, 8'h80, 1'b1}, // R9
    {3'd6, 8'h12, 8'h40, 8'h00, 8'h52, 8'h00, 1'b1}, // R9
    {3'd7, 8'h10, 8'h20, 8'h00, 8'hF0, 8'h50, 1'b0}, // R11
    {3'd7, 8'h3A, 8'h3A, 8'h00, 8'h00, 8'hC0, 1'b0}  // R11
  };

  function automatic logic [16:0] model(logic [2:0] op, logic [7:0] a, logic [7:0] b,
                                        logic [7:0] fin);
    logic       c, z, n, h, cy, we;
    logic [8:0] t;
    logic [7:0] r;
    c  = (op == 3'd1 || op == 3'd3) ? fin[4] : 1'b0;
    n = 1'b0; h = 1'b0; cy = 1'b0;
    case (op)
      3'd0, 3'd1: begin
        t = {1'b0, a} + {1'b0, b} + {8'h00, c};
        r = t[7:0]; cy = t[8];
        h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'h0, c}) > 5'h0F;
      end
      3'd2, 3'd3, 3'd7: begin
        r  = a - b - {7'h0, c};
        n  = 1'b1;
        cy = (a < b) || (a == b && c);
        h  = (a[3:0] < b[3:0]) || (a[3:0] == b[3:0] && c);
      end
      3'd4: begin r = a & b; h = 1'b1; end
      3'd5: r = a ^ b;
      default: r = a | b;
    endcase
    z  = (r == 8'h00);
    we = (op != 3'd7);
    return {we, r, z, n, h, cy, 4'h0};
  endfunction

  task automatic apply(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] fin);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flags_i = fin;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%0d a=%h b=%h fin=%h actual we/res/flg=%h expected=%h",
               req, op_i, a_i, b_i, flags_i, act, exp);
    end
  endtask

  localparam logic [7:0] PICK [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF0, 8'hFF};

  initial begin
    logic [16:0] ref_out;
    op_i = 3'd0; a_i = 8'h00; b_i = 8'h00; flags_i = 8'h00;
    // idle-state check: zero inputs give a zero add with only the zero flag (R10, R1)
    apply(3'd0, 8'h00, 8'h00, 8'h00);
    check("R10", {acc_we_o, result_o, flags_o}, {1'b1, 8'h00, 8'h80});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][43:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      check("R2/table", {acc_we_o, result_o, flags_o}, {VEC[i][0], VEC[i][16:9], VEC[i][8:1]});
    end

    // R7: equal operands through subtract-with-borrow
    for (int k = 0; k < 256; k += 51) begin
      apply(3'd3, 8'(k), 8'(k), 8'h00);
      check("R7", {acc_we_o, result_o, flags_o}, {1'b1, 8'h00, 8'hC0});
      apply(3'd3, 8'(k), 8'(k), 8'h10);
      check("R7", {acc_we_o, result_o, flags_o}, {1'b1, 8'hFF, 8'h70});
    end

    // R12: non-carry flag bits are ignored
    for (int op = 0; op < 8; op++) begin
      apply(3'(op), 8'h3C, 8'h0D, 8'h10);
      ref_out = {acc_we_o, result_o, flags_o};
      apply(3'(op), 8'h3C, 8'h0D, 8'hFF);
      check("R12", {acc_we_o, result_o, flags_o}, ref_out);
      apply(3'(op), 8'h3C, 8'h0D, 8'h00);
      ref_out = {acc_we_o, result_o, flags_o};
      apply(3'(op), 8'h3C, 8'h0D, 8'hEF);
      check("R12", {acc_we_o, result_o, flags_o}, ref_out);
    end

    // R3 R4 R5 R6 R8 R9 R11 R1: sweep against the requirement model
    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int cb = 0; cb < 2; cb++) begin
            apply(3'(op), PICK[ia], PICK[ib], cb[0] ? 8'h10 : 8'h00);
            check("R3-R11 sweep", {acc_we_o, result_o, flags_o},
                  model(3'(op), PICK[ia], PICK[ib], cb[0] ? 8'h10 : 8'h00));
          end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule